// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block decides which of four DMA channels gets serviced, and in what order. It scans the channels in one pass, and each channel is taken in turn. A channel is serviced when its mask bit is clear and its request bit is set. The block then drives a transfer handshake to a peripheral model. With the request it presents:

- the physical start address,
- the current position in the block,
- the total block length.

The peripheral answers with a done strobe and the new position. The block passes that position back as a count update. It raises a one-cycle terminal-count pulse when the position reaches the block length.

A pass in which any channel was serviced is followed by another pass. The scheduler keeps circling while work remains and goes idle after a pass that finds nothing to do. A kick that arrives while a pass is running never restarts or nests the scan. It is remembered and turned into one extra pass after the current one ends.

The block also holds the per-channel page and high-page bytes. They are written and read through a small byte port whose offsets map to channels in a fixed, scrambled order.

Top module: `dma_svc_sched`

## Requirements
- R1: After reset `busy`, `xfer_req`, `cnt_upd` and `tc_pulse` are 0, and every page and high-page byte reads back as 0.
- R2: A channel is serviced only when its `ch_mask` bit is 0 and its `ch_req` bit is 1. Every other channel is skipped without a handshake or count update.
- R3: Within one pass, channels are visited in ascending order, 0 to 3. Each channel is serviced at most once per pass.
- R4: `xfer_len` equals (base count + 1) shifted left by `wshift`.
- R5: While `xfer_done` is high, if `xfer_newpos` equals `xfer_len`, then `tc_pulse` is high for that one cycle on the bit of the serviced channel. Otherwise `tc_pulse` stays 0.
- R6: A pass that serviced at least one channel is followed by another pass. A pass that serviced none returns the block to idle (`busy` low).
- R7: A `kick` during a pass does not restart the scan. It causes exactly one further pass after the current pass ends.
- R8: The base physical address is {high page[6:0], page[7:0], current address[15:0]}. When mode bit 5 is 0, `xfer_phys` is that base plus the position, and `xfer_pos` is the channel's current position.
- R9: When mode bit 5 is 1 (decrement), `xfer_phys` is the base address minus the position minus the length, modulo 2^31.
- R10: On the page port, offset 1 selects channel 2, offset 2 selects channel 3, offset 3 selects channel 1 and offset 7 selects channel 0. `pg_high` picks the high-page byte over the page byte. Writes to offsets 0, 4, 5 and 6 change nothing, and reads there return 0.
- R11: `xfer_chan` equals the local channel number plus 4 times `wshift`.
- R12: When `periph_present` is 0 for an eligible channel, no handshake is raised for it. A one-cycle count update reports its position unchanged, and no terminal-count pulse occurs.
- R13: The cycle of `xfer_done` carries `cnt_upd` high, with `cnt_upd_ch` equal to the serviced channel and `cnt_upd_pos` equal to `xfer_newpos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Request a scan pass |
| wshift | input | 1 | Transfer width shift (0 byte, 1 word) |
| ch_mask | input | 4 | Per-channel mask, 1 = masked |
| ch_req | input | 4 | Per-channel pending request |
| periph_present | input | 4 | Per-channel peripheral attached |
| mode_flat | input | 32 | Mode byte per channel; bit 5 = decrement |
| base_cnt_flat | input | 64 | Base count per channel |
| cur_addr_flat | input | 64 | Current address per channel |
| cur_pos_flat | input | 72 | Current position per channel |
| pg_we | input | 1 | Page port write strobe |
| pg_high | input | 1 | Select high-page bank |
| pg_off | input | 3 | Page port offset |
| pg_wdata | input | 8 | Page port write data |
| pg_rdata | output | 8 | Page port read data |
| xfer_req | output | 1 | Transfer handshake request |
| xfer_chan | output | 3 | Reported channel number |
| xfer_phys | output | 31 | Physical start address |
| xfer_pos | output | 18 | Current position of the channel |
| xfer_len | output | 18 | Total block length |
| xfer_done | input | 1 | Peripheral finished this transfer |
| xfer_newpos | input | 18 | Position returned by the peripheral |
| cnt_upd | output | 1 | Count update strobe |
| cnt_upd_ch | output | 2 | Channel of the count update |
| cnt_upd_pos | output | 18 | Updated position |
| tc_pulse | output | 4 | Terminal-count pulses |
| busy | output | 1 | A pass is running or pending |

## Verification
The hardest case to reach is a kick that lands in the middle of a pass that would otherwise service nothing. Only in that case does the deferred-kick flag alone decide whether a second pass runs.

The stimulus reaches it as follows:
1. Start a pass with every channel masked.
2. Two cycles later, once the scan has moved past channel 0, unmask channel 0 and pulse the kick again.
3. Require channel 0 to be serviced in the pass that follows.

The second hard case is a channel with no attached peripheral. Left alone it keeps the scheduler rearming. The bench therefore masks that channel one cycle after seeing its silent count update.

Random rounds with a fixed seed cover the rest: eligibility patterns, page values, addresses, decrement mode and width shift. Each eligible channel first gets a half-length answer, then a full-length one, so every round exercises the rearm path.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

   typedef enum logic [1:0] {
      SCH_IDLE = 2'd0,
      SCH_SCAN = 2'd1,
      SCH_WAIT = 2'd2,
      SCH_DONE = 2'd3
   } sch_state_e;

   localparam int MODE_W       = 8;
   localparam int MODE_DEC_BIT = 5;
   localparam int PORT_OFF_W   = 3;

   // Page port decode: returns {hit, channel[1:0]}
   function automatic logic [2:0] page_port_map(input logic [PORT_OFF_W-1:0] off);
      logic [2:0] r;
      case (off)
         3'd1:    r = {1'b1, 2'd2};
         3'd2:    r = {1'b1, 2'd3};
         3'd3:    r = {1'b1, 2'd1};
         3'd7:    r = {1'b1, 2'd0};
         default: r = 3'b000;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dma_page_regs.sv
module dma_page_regs
   import dma_sched_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int PAGE_W       = 8,
   parameter int HPAGE_W      = 7,
   parameter bit HIGH_PAGE_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pg_we,
   input  logic                      pg_high,
   input  logic [PORT_OFF_W-1:0]     pg_off,
   input  logic [PAGE_W-1:0]         pg_wdata,
   output logic [PAGE_W-1:0]         pg_rdata,
   output logic [NCH*PAGE_W-1:0]     page_flat,
   output logic [NCH*HPAGE_W-1:0]    hpage_flat
);

   logic [NCH-1:0][PAGE_W-1:0] lo_q;
   logic [NCH-1:0][PAGE_W-1:0] hi_q;
   logic [2:0]                 map;
   logic                       hit;
   logic [1:0]                 tgt;

   always_comb begin
      map = page_port_map(pg_off);
      hit = map[2];
      tgt = map[1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (pg_we && hit && !pg_high) begin
         lo_q[tgt] <= pg_wdata;
      end
   end

   generate
      if (HIGH_PAGE_EN) begin : g_hi_bank
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q <= '0;
            end else if (pg_we && hit && pg_high) begin
               hi_q[tgt] <= pg_wdata;
            end
         end
      end else begin : g_no_hi_bank
         assign hi_q = '0;
      end
   endgenerate

   always_comb begin
      pg_rdata = '0;
      if (hit) begin
         pg_rdata = pg_high ? hi_q[tgt] : lo_q[tgt];
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_flat
      assign page_flat[c*PAGE_W +: PAGE_W]    = lo_q[c];
      assign hpage_flat[c*HPAGE_W +: HPAGE_W] = hi_q[c][HPAGE_W-1:0];
   end

   // R10
   inv_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_we && !hit) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_sched_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int ADDR_W  = 16,
   parameter int PAGE_W  = 8,
   parameter int HPAGE_W = 7,
   parameter int CNT_W   = 16,
   parameter int LEN_W   = CNT_W + 2,
   parameter int PHYS_W  = HPAGE_W + PAGE_W + ADDR_W
) (
   input  logic [$clog2(NCH)-1:0]    sel,
   input  logic                      wshift,
   input  logic [NCH*MODE_W-1:0]     mode_flat,
   input  logic [NCH*CNT_W-1:0]      base_cnt_flat,
   input  logic [NCH*ADDR_W-1:0]     cur_addr_flat,
   input  logic [NCH*LEN_W-1:0]      cur_pos_flat,
   input  logic [NCH*PAGE_W-1:0]     page_flat,
   input  logic [NCH*HPAGE_W-1:0]    hpage_flat,
   output logic [PHYS_W-1:0]         phys_out,
   output logic [LEN_W-1:0]          len_out,
   output logic [LEN_W-1:0]          pos_out
);

   logic [MODE_W-1:0]  mode_s;
   logic [CNT_W-1:0]   base_s;
   logic [ADDR_W-1:0]  addr_s;
   logic [PAGE_W-1:0]  page_s;
   logic [HPAGE_W-1:0] hpage_s;
   logic [LEN_W-1:0]   len_raw;
   logic [PHYS_W-1:0]  phys_base;

   always_comb begin
      mode_s  = mode_flat[sel*MODE_W +: MODE_W];
      base_s  = base_cnt_flat[sel*CNT_W +: CNT_W];
      addr_s  = cur_addr_flat[sel*ADDR_W +: ADDR_W];
      page_s  = page_flat[sel*PAGE_W +: PAGE_W];
      hpage_s = hpage_flat[sel*HPAGE_W +: HPAGE_W];
      pos_out = cur_pos_flat[sel*LEN_W +: LEN_W];

      len_raw = LEN_W'(base_s) + LEN_W'(1);
      len_out = wshift ? (len_raw << 1) : len_raw;

      phys_base = {hpage_s, page_s, addr_s};
      if (mode_s[MODE_DEC_BIT]) begin
         phys_out = phys_base - PHYS_W'(pos_out) - PHYS_W'(len_out);
      end else begin
         phys_out = phys_base + PHYS_W'(pos_out);
      end
   end

endmodule

// File: rtl/dma_scan_fsm.sv
module dma_scan_fsm
   import dma_sched_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int LEN_W = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    kick,
   input  logic [NCH-1:0]          ch_mask,
   input  logic [NCH-1:0]          ch_req,
   input  logic [NCH-1:0]          periph_present,
   input  logic [LEN_W-1:0]        cur_pos_sel,
   input  logic [LEN_W-1:0]        xfer_len,
   input  logic                    xfer_done,
   input  logic [LEN_W-1:0]        xfer_newpos,
   output logic [$clog2(NCH)-1:0]  sel,
   output logic                    xfer_req,
   output logic                    cnt_upd,
   output logic [LEN_W-1:0]        cnt_upd_pos,
   output logic [NCH-1:0]          tc_pulse,
   output logic                    busy
);

   localparam int CH_W = $clog2(NCH);

   sch_state_e      state_q;
   logic [CH_W-1:0] sel_q;
   logic            svc_q;
   logic            pend_q;
   logic            elig;
   logic            last;

   assign elig = !ch_mask[sel_q] && ch_req[sel_q];
   assign last = (sel_q == CH_W'(NCH-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SCH_IDLE;
         sel_q   <= '0;
         svc_q   <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         case (state_q)
            SCH_IDLE: begin
               if (kick) begin
                  state_q <= SCH_SCAN;
                  sel_q   <= '0;
                  svc_q   <= 1'b0;
                  pend_q  <= 1'b0;
               end
            end
            SCH_SCAN: begin
               if (kick) pend_q <= 1'b1;
               if (elig && periph_present[sel_q]) begin
                  state_q <= SCH_WAIT;
                  svc_q   <= 1'b1;
               end else begin
                  if (elig) svc_q <= 1'b1;
                  if (last) state_q <= SCH_DONE;
                  else      sel_q   <= sel_q + CH_W'(1);
               end
            end
            SCH_WAIT: begin
               if (kick) pend_q <= 1'b1;
               if (xfer_done) begin
                  if (last) begin
                     state_q <= SCH_DONE;
                  end else begin
                     state_q <= SCH_SCAN;
                     sel_q   <= sel_q + CH_W'(1);
                  end
               end
            end
            SCH_DONE: begin
               if (svc_q || pend_q || kick) begin
                  state_q <= SCH_SCAN;
                  sel_q   <= '0;
                  svc_q   <= 1'b0;
                  pend_q  <= 1'b0;
               end else begin
                  state_q <= SCH_IDLE;
               end
            end
            default: state_q <= SCH_IDLE;
         endcase
      end
   end

   always_comb begin
      sel         = sel_q;
      busy        = (state_q != SCH_IDLE);
      xfer_req    = (state_q == SCH_WAIT);
      cnt_upd     = ((state_q == SCH_WAIT) && xfer_done) ||
                    ((state_q == SCH_SCAN) && elig && !periph_present[sel_q]);
      cnt_upd_pos = (state_q == SCH_WAIT) ? xfer_newpos : cur_pos_sel;
      for (int i = 0; i < NCH; i++) begin
         tc_pulse[i] = (state_q == SCH_WAIT) && xfer_done &&
                       (xfer_newpos == xfer_len) && (sel_q == CH_W'(i));
      end
   end

   // R2
   serve_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_req) |-> ($past(ch_req[sel_q]) && !$past(ch_mask[sel_q])));

   // R5
   tc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tc_pulse));

   // R5
   tc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_pulse) |-> (xfer_done && xfer_newpos == xfer_len));

   // R12
   tc_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_pulse) |-> periph_present[sel_q]);

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!xfer_req && !cnt_upd));

   // R3
   sel_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_upd |=> (!cnt_upd || sel_q > $past(sel_q)));

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SCH_SCAN && sel_q != '0) |=> !(state_q == SCH_SCAN && sel_q == '0));

endmodule

// File: rtl/dma_svc_sched.sv
module dma_svc_sched
   import dma_sched_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int ADDR_W       = 16,
   parameter int CNT_W        = 16,
   parameter int PAGE_W       = 8,
   parameter int HPAGE_W      = 7,
   parameter bit HIGH_PAGE_EN = 1'b1,
   parameter int LEN_W        = CNT_W + 2,
   parameter int PHYS_W       = HPAGE_W + PAGE_W + ADDR_W,
   parameter int CH_W         = $clog2(NCH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      kick,
   input  logic                      wshift,
   input  logic [NCH-1:0]            ch_mask,
   input  logic [NCH-1:0]            ch_req,
   input  logic [NCH-1:0]            periph_present,
   input  logic [NCH*MODE_W-1:0]     mode_flat,
   input  logic [NCH*CNT_W-1:0]      base_cnt_flat,
   input  logic [NCH*ADDR_W-1:0]     cur_addr_flat,
   input  logic [NCH*LEN_W-1:0]      cur_pos_flat,
   input  logic                      pg_we,
   input  logic                      pg_high,
   input  logic [PORT_OFF_W-1:0]     pg_off,
   input  logic [PAGE_W-1:0]         pg_wdata,
   output logic [PAGE_W-1:0]         pg_rdata,
   output logic                      xfer_req,
   output logic [CH_W:0]             xfer_chan,
   output logic [PHYS_W-1:0]         xfer_phys,
   output logic [LEN_W-1:0]          xfer_pos,
   output logic [LEN_W-1:0]          xfer_len,
   input  logic                      xfer_done,
   input  logic [LEN_W-1:0]          xfer_newpos,
   output logic                      cnt_upd,
   output logic [CH_W-1:0]           cnt_upd_ch,
   output logic [LEN_W-1:0]          cnt_upd_pos,
   output logic [NCH-1:0]            tc_pulse,
   output logic                      busy
);

   generate
      if (NCH != 4) begin : g_bad_nch
         $error("dma_svc_sched: the page port decode serves exactly four channels");
      end
      if (HPAGE_W > PAGE_W) begin : g_bad_hpage
         $error("dma_svc_sched: high page field wider than the page byte");
      end
      if (LEN_W < CNT_W + 2) begin : g_bad_len
         $error("dma_svc_sched: length width cannot hold a shifted full count");
      end
   endgenerate

   logic [NCH*PAGE_W-1:0]  page_flat;
   logic [NCH*HPAGE_W-1:0] hpage_flat;
   logic [CH_W-1:0]        sel;

   dma_page_regs #(
      .NCH          (NCH),
      .PAGE_W       (PAGE_W),
      .HPAGE_W      (HPAGE_W),
      .HIGH_PAGE_EN (HIGH_PAGE_EN)
   ) u_pages (
      .clk        (clk),
      .rst_n      (rst_n),
      .pg_we      (pg_we),
      .pg_high    (pg_high),
      .pg_off     (pg_off),
      .pg_wdata   (pg_wdata),
      .pg_rdata   (pg_rdata),
      .page_flat  (page_flat),
      .hpage_flat (hpage_flat)
   );

   dma_addr_gen #(
      .NCH     (NCH),
      .ADDR_W  (ADDR_W),
      .PAGE_W  (PAGE_W),
      .HPAGE_W (HPAGE_W),
      .CNT_W   (CNT_W),
      .LEN_W   (LEN_W),
      .PHYS_W  (PHYS_W)
   ) u_addr (
      .sel           (sel),
      .wshift        (wshift),
      .mode_flat     (mode_flat),
      .base_cnt_flat (base_cnt_flat),
      .cur_addr_flat (cur_addr_flat),
      .cur_pos_flat  (cur_pos_flat),
      .page_flat     (page_flat),
      .hpage_flat    (hpage_flat),
      .phys_out      (xfer_phys),
      .len_out       (xfer_len),
      .pos_out       (xfer_pos)
   );

   dma_scan_fsm #(
      .NCH   (NCH),
      .LEN_W (LEN_W)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .kick           (kick),
      .ch_mask        (ch_mask),
      .ch_req         (ch_req),
      .periph_present (periph_present),
      .cur_pos_sel    (xfer_pos),
      .xfer_len       (xfer_len),
      .xfer_done      (xfer_done),
      .xfer_newpos    (xfer_newpos),
      .sel            (sel),
      .xfer_req       (xfer_req),
      .cnt_upd        (cnt_upd),
      .cnt_upd_pos    (cnt_upd_pos),
      .tc_pulse       (tc_pulse),
      .busy           (busy)
   );

   assign cnt_upd_ch = sel;
   assign xfer_chan  = (CH_W+1)'(sel) + (wshift ? (CH_W+1)'(NCH) : '0);

endmodule

// File: tb/dma_svc_sched_test.sv
`timescale 1ns/1ps
module dma_svc_sched_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick = 1'b0;
   logic        wshift = 1'b0;
   logic [3:0]  ch_mask = 4'hF;
   logic [3:0]  ch_req = 4'h0;
   logic [3:0]  periph_present = 4'hF;
   logic [31:0] mode_flat = '0;
   logic [63:0] base_cnt_flat = '0;
   logic [63:0] cur_addr_flat = '0;
   logic [71:0] cur_pos_flat = '0;
   logic        pg_we = 1'b0;
   logic        pg_high = 1'b0;
   logic [2:0]  pg_off = '0;
   logic [7:0]  pg_wdata = '0;
   logic [7:0]  pg_rdata;
   logic        xfer_req;
   logic [2:0]  xfer_chan;
   logic [30:0] xfer_phys;
   logic [17:0] xfer_pos;
   logic [17:0] xfer_len;
   logic        xfer_done = 1'b0;
   logic [17:0] xfer_newpos = '0;
   logic        cnt_upd;
   logic [1:0]  cnt_upd_ch;
   logic [17:0] cnt_upd_pos;
   logic [3:0]  tc_pulse;
   logic        busy;

   dma_svc_sched uut (
      .clk(clk), .rst_n(rst_n), .kick(kick), .wshift(wshift),
      .ch_mask(ch_mask), .ch_req(ch_req), .periph_present(periph_present),
      .mode_flat(mode_flat), .base_cnt_flat(base_cnt_flat),
      .cur_addr_flat(cur_addr_flat), .cur_pos_flat(cur_pos_flat),
      .pg_we(pg_we), .pg_high(pg_high), .pg_off(pg_off), .pg_wdata(pg_wdata),
      .pg_rdata(pg_rdata), .xfer_req(xfer_req), .xfer_chan(xfer_chan),
      .xfer_phys(xfer_phys), .xfer_pos(xfer_pos), .xfer_len(xfer_len),
      .xfer_done(xfer_done), .xfer_newpos(xfer_newpos), .cnt_upd(cnt_upd),
      .cnt_upd_ch(cnt_upd_ch), .cnt_upd_pos(cnt_upd_pos),
      .tc_pulse(tc_pulse), .busy(busy)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [15:0] t_base [4];
   logic [15:0] t_addr [4];
   logic [17:0] t_pos  [4];
   logic [7:0]  t_mode [4];
   logic [7:0]  t_pg   [4];
   logic [7:0]  t_hp   [4];
   int          exp_seq [16];
   int          nexp;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [17:0] exp_len(input int c);
      logic [17:0] l;
      l = 18'(t_base[c]) + 18'd1;
      return wshift ? (l << 1) : l;
   endfunction

   function automatic logic [30:0] exp_phys(input int c, input logic [17:0] p);
      logic [30:0] b;
      b = {t_hp[c][6:0], t_pg[c], t_addr[c]};
      if (t_mode[c][5]) return b - 31'(p) - 31'(exp_len(c));
      return b + 31'(p);
   endfunction

   function automatic int chan_to_off(input int c);
      case (c)
         0: return 7;
         1: return 3;
         2: return 1;
         default: return 2;
      endcase
   endfunction

   task automatic push();
      for (int c = 0; c < 4; c++) begin
         mode_flat[c*8 +: 8]      = t_mode[c];
         base_cnt_flat[c*16 +: 16] = t_base[c];
         cur_addr_flat[c*16 +: 16] = t_addr[c];
         cur_pos_flat[c*18 +: 18]  = t_pos[c];
      end
   endtask

   task automatic pg_write(input bit hi, input int off, input logic [7:0] d);
      @(negedge clk);
      pg_we = 1'b1; pg_high = hi; pg_off = 3'(off); pg_wdata = d;
      @(negedge clk);
      pg_we = 1'b0;
   endtask

   task automatic pg_read(input bit hi, input int off, output logic [7:0] d);
      @(negedge clk);
      pg_high = hi; pg_off = 3'(off);
      #1 d = pg_rdata;
   endtask

   task automatic load_pages();
      for (int c = 0; c < 4; c++) begin
         pg_write(1'b0, chan_to_off(c), t_pg[c]);
         pg_write(1'b1, chan_to_off(c), t_hp[c]);
      end
   endtask

   task automatic do_kick();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
   endtask

   task automatic build_exp();
      nexp = 0;
      for (int rep = 0; rep < 2; rep++)
         for (int c = 0; c < 4; c++)
            if (!ch_mask[c] && ch_req[c] && periph_present[c]) begin
               exp_seq[nexp] = c;
               nexp++;
            end
   endtask

   // Serves handshakes until the block goes idle; first answer is half length, then full.
   task automatic serve(output int unreg);
      int ng;
      logic [3:0] drop, mnext;
      ng = 0; unreg = 0; drop = 0; mnext = 0;
      for (int cyc = 0; cyc < 2000; cyc++) begin
         @(negedge clk);
         xfer_done = 1'b0;
         ch_req  = ch_req & ~drop;
         ch_mask = ch_mask | mnext;
         drop = 0; mnext = 0;
         #1;
         if (!busy) break;
         if (xfer_req) begin
            int a;
            logic [17:0] np, ln;
            a = int'(xfer_chan[1:0]);
            if (ng < nexp) chk(a == exp_seq[ng], "R3 service order", a, exp_seq[ng]);
            else chk(1'b0, "R2 unexpected service", a, 99);
            ng++;
            chk(!ch_mask[a] && ch_req[a], "R2 eligibility", {ch_mask[a], ch_req[a]}, 2'b01);
            chk(xfer_chan == 3'(a + 4*int'(wshift)), "R11 channel number", xfer_chan, a + 4*int'(wshift));
            ln = exp_len(a);
            chk(xfer_len == ln, "R4 length", xfer_len, ln);
            chk(xfer_pos == t_pos[a], "R8 position", xfer_pos, t_pos[a]);
            chk(xfer_phys == exp_phys(a, t_pos[a]),
                t_mode[a][5] ? "R9 decrement address" : "R8 address",
                xfer_phys, exp_phys(a, t_pos[a]));
            np = (t_pos[a] == 0) ? (ln >> 1) : ln;
            xfer_newpos = np;
            xfer_done = 1'b1;
            #1;
            chk(cnt_upd && cnt_upd_ch == 2'(a) && cnt_upd_pos == np, "R13 count update",
                {cnt_upd, cnt_upd_ch, cnt_upd_pos}, {1'b1, 2'(a), np});
            chk(tc_pulse == ((np == ln) ? (4'b1 << a) : 4'b0), "R5 terminal count",
                tc_pulse, (np == ln) ? (4'b1 << a) : 4'b0);
            t_pos[a] = np;
            push();
            if (np == ln) drop[a] = 1'b1;
         end else if (cnt_upd) begin
            chk(!periph_present[cnt_upd_ch] && cnt_upd_pos == t_pos[cnt_upd_ch] && tc_pulse == 0,
                "R12 absent peripheral update", {tc_pulse, cnt_upd_pos}, {4'b0, t_pos[cnt_upd_ch]});
            unreg++;
            mnext[cnt_upd_ch] = 1'b1;
         end else if (tc_pulse != 0) begin
            chk(1'b0, "R5 stray terminal count", tc_pulse, 0);
         end
      end
      chk(ng == nexp, "R6 rearm pass count", ng, nexp);
      chk(!busy, "R6 returns idle", busy, 0);
   endtask

   initial begin
      logic [7:0] rd;
      int un;
      void'($urandom(32'd4242));
      for (int c = 0; c < 4; c++) begin
         t_base[c] = 16'd3; t_addr[c] = 0; t_pos[c] = 0; t_mode[c] = 0; t_pg[c] = 0; t_hp[c] = 0;
      end
      push();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1
      chk(!busy && !xfer_req && !cnt_upd && tc_pulse == 0, "R1 reset outputs",
          {busy, xfer_req, cnt_upd, tc_pulse}, 0);
      for (int o = 0; o < 8; o++) begin
         pg_read(1'b0, o, rd); chk(rd == 0, "R1 page reset", rd, 0);
         pg_read(1'b1, o, rd); chk(rd == 0, "R1 high page reset", rd, 0);
      end

      // R10: mapping through addresses, invalid offsets ignored
      for (int c = 0; c < 4; c++) begin
         t_pg[c] = 8'h11 * 8'(c + 1); t_hp[c] = 8'hF0 | 8'(c);
      end
      load_pages();
      foreach (t_pg[i]) begin end
      for (int o = 0; o < 8; o++)
         if (o == 0 || o == 4 || o == 5 || o == 6) begin
            pg_write(1'b0, o, 8'hAA);
            pg_write(1'b1, o, 8'h55);
         end
      for (int c = 0; c < 4; c++) begin
         pg_read(1'b0, chan_to_off(c), rd); chk(rd == t_pg[c], "R10 page readback", rd, t_pg[c]);
         pg_read(1'b1, chan_to_off(c), rd); chk(rd == t_hp[c], "R10 high readback", rd, t_hp[c]);
      end
      for (int o = 4; o < 7; o++) begin
         pg_read(1'b0, o, rd); chk(rd == 0, "R10 invalid read", rd, 0);
      end
      pg_read(1'b1, 0, rd); chk(rd == 0, "R10 invalid read", rd, 0);

      // R8 R11: all channels, increment mode, high page top bit dropped
      for (int c = 0; c < 4; c++) begin
         t_addr[c] = 16'h1000 * 16'(c + 1); t_base[c] = 16'd9 + 16'(c); t_pos[c] = 0;
      end
      ch_mask = 4'h0; ch_req = 4'hF; periph_present = 4'hF; wshift = 1'b0;
      push(); build_exp(); do_kick(); serve(un);

      // R9 R4 R11: decrement with wrap and word width
      for (int c = 0; c < 4; c++) begin
         t_mode[c] = 8'h20; t_addr[c] = 16'h0002; t_pos[c] = 0; t_pg[c] = 0; t_hp[c] = 0;
      end
      load_pages();
      wshift = 1'b1; ch_mask = 4'b0100; ch_req = 4'b1111;
      push(); build_exp(); do_kick(); serve(un);

      // R7: kick during a pass that would service nothing
      for (int c = 0; c < 4; c++) begin t_mode[c] = 0; t_pos[c] = 0; end
      wshift = 1'b0; ch_mask = 4'hF; ch_req = 4'b0001; push();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      @(negedge clk); ch_mask = 4'b1110; kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      nexp = 2; exp_seq[0] = 0; exp_seq[1] = 0;
      serve(un);
      chk(t_pos[0] == exp_len(0), "R7 deferred kick serviced channel 0", t_pos[0], exp_len(0));

      // R12: absent peripheral on channel 2
      for (int c = 0; c < 4; c++) t_pos[c] = 0;
      t_pos[2] = 18'd5;
      periph_present = 4'b1011; ch_mask = 4'b0000; ch_req = 4'b0101;
      push(); build_exp(); do_kick(); serve(un);
      chk(un == 1, "R12 absent peripheral updates", un, 1);
      chk(t_pos[2] == 18'd5, "R12 position unchanged", t_pos[2], 5);
      periph_present = 4'hF;

      // Random rounds: R2 R3 R4 R5 R6 R8 R9 R11
      for (int r = 0; r < 10; r++) begin
         for (int c = 0; c < 4; c++) begin
            t_base[c] = 16'($urandom_range(1, 300));
            t_addr[c] = 16'($urandom);
            t_mode[c] = 8'($urandom) & 8'h20;
            t_pg[c]   = 8'($urandom);
            t_hp[c]   = 8'($urandom);
            t_pos[c]  = 0;
         end
         load_pages();
         wshift  = 1'($urandom);
         ch_mask = 4'($urandom);
         ch_req  = 4'($urandom);
         push(); build_exp(); do_kick(); serve(un);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule